// File: doc/BRIEF.md
# Programmable Countdown Timer

A 32-bit down-counter with a small word-addressed register port. Software writes a reload value, then issues start and stop commands through the control register. A control bit selects one-shot or auto-reload operation. The counter advances only on cycles where the tick-enable input is high. This lets a shared prescaler set the time base without a second clock.

When the count runs out, a sticky timeout flag is set. In auto-reload mode the counter reloads and keeps going. In one-shot mode it halts at zero. A level interrupt is the timeout flag gated by an enable bit, so software acknowledges an interrupt by writing the status register. A read-only register returns the live count at any time.

Top module: `countdown_timer`

## Requirements
- R1: After reset every register reads as zero, the counter is halted and `irq_o` is low.
- R2: Registers are selected by byte offset: status 0x0, control 0x4, reload 0x8, live count 0xC. Status bit 0 is the timeout flag and bit 1 is the running flag; all other status bits read zero.
- R3: A write of any value to status clears the timeout flag and leaves the running flag unchanged. An expiry on the same edge keeps the flag set.
- R4: A control write stores all 32 bits, which read back unchanged. Bit 2 set starts the counter and bit 3 set halts it. Bit 3 wins when both are set, and either command overrides an expiry on the same edge.
- R5: A write to the reload register stores the value and also copies it into the counter, taking precedence over a decrement or reload on the same edge.
- R6: Reading offset 0xC returns the current count; writes to it change no register.
- R7: While running, the count drops by one on each edge where `tick_i` is high and holds when `tick_i` is low. While halted it always holds.
- R8: The count expires on a tick that takes it from 1 to 0, or on the first edge of running with a count of 0, whether or not a tick is present. Expiry sets the timeout flag.
- R9: With control bit 1 set, expiry reloads the count from the reload register and keeps running. With it clear, expiry leaves the count at 0 and halts.
- R10: `irq_o` is high exactly when the timeout flag and control bit 0 are both set.
- R11: Accesses with address bits [1:0] non-zero, or at any offset of 0x10 and above, read zero and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable strobe |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from address in the access cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is combinational, so a read is sampled 1 ns after the address is applied, with no clock edge. Every register change lands on the edge that carries the write or tick. The bench therefore samples 1 ns after that edge, and `irq_o` and the status bits are due in the same window. During the sweep the bench drives a tick on every edge or on every second edge after a start. It counts ticks n and expects the one-shot count to be max(P-n,0). In auto-reload it expects P-(n mod P), and the timeout flag from the tick where n reaches P. A reload of 0 expires on the first edge after the start.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    REG_STAT   = 2'd0,
    REG_CTRL   = 2'd1,
    REG_RELOAD = 2'd2,
    REG_LIVE   = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_IEN  = 0;
  localparam int unsigned CTL_AUTO = 1;
  localparam int unsigned CTL_GO   = 2;
  localparam int unsigned CTL_HALT = 3;

  localparam int unsigned ST_TO  = 0;
  localparam int unsigned ST_RUN = 1;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output reg_sel_e          sel_o
);
  logic hi_zero;

  generate
    if (ADDR_W > 4) begin : g_hi
      assign hi_zero = (addr_i[ADDR_W-1:4] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  // word accesses only: misaligned offsets are treated as unmapped
  assign hit_o = hi_zero && (addr_i[1:0] == 2'b00);
  assign sel_o = reg_sel_e'(addr_i[3:2]);
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stat_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_reload_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              to_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      reload_o <= '0;
      to_o     <= 1'b0;
    end else begin
      if (wr_ctrl_i)   ctrl_o   <= wdata_i;
      if (wr_reload_i) reload_o <= wdata_i;
      // expiry beats an acknowledge on the same edge
      if (expire_i)       to_o <= 1'b1;
      else if (wr_stat_i) to_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cdt_count.sv
module cdt_count #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              go_i,
  input  logic              halt_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              auto_i,
  output logic [DATA_W-1:0] count_o,
  output logic              run_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic at_zero;
  assign at_zero  = (count_o == '0);
  assign expire_o = run_o && (at_zero || (tick_i && count_o == ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      run_o   <= 1'b0;
    end else begin
      if (load_i)               count_o <= load_val_i;
      else if (expire_o)        count_o <= auto_i ? reload_i : '0;
      else if (run_o && tick_i) count_o <= count_o - ONE;

      if (halt_i)                  run_o <= 1'b0;
      else if (go_i)               run_o <= 1'b1;
      else if (expire_o && !auto_i) run_o <= 1'b0;
    end
  end
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              hit_w;
  reg_sel_e          sel_w;
  logic              wr_w, wr_stat_w, wr_ctrl_w, wr_reload_w;
  logic [DATA_W-1:0] ctrl_w, reload_w, count_w, status_w;
  logic              to_w, run_w, expire_w;

  cdt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit_w),
    .sel_o  (sel_w)
  );

  assign wr_w        = req_i && we_i && hit_w;
  assign wr_stat_w   = wr_w && (sel_w == REG_STAT);
  assign wr_ctrl_w   = wr_w && (sel_w == REG_CTRL);
  assign wr_reload_w = wr_w && (sel_w == REG_RELOAD);

  cdt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_stat_i   (wr_stat_w),
    .wr_ctrl_i   (wr_ctrl_w),
    .wr_reload_i (wr_reload_w),
    .wdata_i     (wdata_i),
    .expire_i    (expire_w),
    .ctrl_o      (ctrl_w),
    .reload_o    (reload_w),
    .to_o        (to_w)
  );

  cdt_count #(.DATA_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .go_i       (wr_ctrl_w && wdata_i[CTL_GO]),
    .halt_i     (wr_ctrl_w && wdata_i[CTL_HALT]),
    .load_i     (wr_reload_w),
    .load_val_i (wdata_i),
    .reload_i   (reload_w),
    .auto_i     (ctrl_w[CTL_AUTO]),
    .count_o    (count_w),
    .run_o      (run_w),
    .expire_o   (expire_w)
  );

  always_comb begin
    status_w         = '0;
    status_w[ST_TO]  = to_w;
    status_w[ST_RUN] = run_w;
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && hit_w) begin
      unique case (sel_w)
        REG_STAT:   rdata_o = status_w;
        REG_CTRL:   rdata_o = ctrl_w;
        REG_RELOAD: rdata_o = reload_w;
        REG_LIVE:   rdata_o = count_w;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign irq_o = to_w && ctrl_w[CTL_IEN];
endmodule

// File: rtl/countdown_timer_chk.sv
module countdown_timer_chk
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              expire_i,
  input logic              run_i,
  input logic              to_i,
  input logic [DATA_W-1:0] count_i,
  input logic [DATA_W-1:0] reload_i,
  input logic              auto_i,
  input logic              irq_i
);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(8);

  logic wr, w_stat, w_ctrl, w_rel;
  assign wr     = req_i && we_i;
  assign w_stat = wr && addr_i == A_STAT;
  assign w_ctrl = wr && addr_i == A_CTRL;
  assign w_rel  = wr && addr_i == A_RELOAD;

  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_stat && !expire_i |=> !to_i && !irq_i);

  p_halt_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_ctrl && wdata_i[CTL_HALT] |=> !run_i);

  p_go_runs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_ctrl && wdata_i[CTL_GO] && !wdata_i[CTL_HALT] |=> run_i);

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_rel |=> count_i == $past(wdata_i));

  p_decrement_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && count_i > DATA_W'(1) && !w_rel |=> count_i == $past(count_i) - DATA_W'(1));

  p_expiry_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> to_i);

  p_oneshot_halts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && !auto_i && !w_ctrl && !w_rel |=> !run_i && count_i == '0);

  p_autoreload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && auto_i && !w_ctrl && !w_rel |=> run_i && count_i == $past(reload_i));

  p_halted_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !w_rel |=> $stable(count_i));
endmodule

bind countdown_timer countdown_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .expire_i (expire_w),
  .run_i    (run_w),
  .to_i     (to_w),
  .count_i  (count_w),
  .reload_i (reload_w),
  .auto_i   (ctrl_w[1]),
  .irq_i    (irq_o)
);

// File: tb/countdown_timer_tb.sv
module countdown_timer_tb;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  countdown_timer #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata;
    req = 1'b0;
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(5'h00, v); chk("R1 status", v, 0);
    rd(5'h04, v); chk("R1 ctrl", v, 0);
    rd(5'h08, v); chk("R1 reload", v, 0);
    rd(5'h0C, v); chk("R1 live", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    @(negedge clk); rst_n = 1'b1;

    // sweep: mode x reload x tick spacing (R2 R5 R7 R8 R9 R10)
    for (int mode = 0; mode < 2; mode++) begin
      for (int p = 0; p < 5; p++) begin
        for (int dv = 1; dv <= 2; dv++) begin
          logic [DW-1:0] cw;
          cw = 32'h5 | (mode << 1);
          wr(5'h08, p);
          rd(5'h0C, v); chk("R5 load live", v, p);
          rd(5'h08, v); chk("R5 reload stored", v, p);
          wr(5'h04, cw);
          rd(5'h04, v); chk("R4 ctrl readback", v, cw);
          for (int e = 1; e <= p * dv + 3; e++) begin
            int n, ec, er, et;
            @(negedge clk);
            tick = (e % dv == 0);
            @(posedge clk);
            #1;
            tick = 1'b0;
            n = e / dv;
            if (p == 0) begin
              ec = 0; et = 1; er = mode;
            end else if (mode == 0) begin
              if (n < p) begin ec = p - n; er = 1; et = 0; end
              else       begin ec = 0;     er = 0; et = 1; end
            end else begin
              ec = p - (n % p); er = 1; et = (n >= p);
            end
            rd(5'h0C, v); chk("R7 R8 R9 live", v, ec);
            rd(5'h00, v); chk("R2 R8 status", v, (er << 1) | et);
            chk("R10 irq", {31'b0, irq}, et);
          end
          wr(5'h04, 32'h8);
          wr(5'h00, 32'h0);
          rd(5'h00, v); chk("R3 R4 halted clear", v, 0);
        end
      end
    end

    // R7 hold without tick while running
    wr(5'h08, 32'd7);
    wr(5'h04, 32'h6);
    repeat (3) @(posedge clk);
    #1;
    rd(5'h0C, v); chk("R7 hold no tick", v, 7);

    // R4 start+halt together: halt wins, whole word kept
    wr(5'h04, 32'hC);
    rd(5'h00, v); chk("R4 halt wins run", v, 0);
    rd(5'h04, v); chk("R4 ctrl whole word", v, 32'hC);

    // R3 R10: flag set with interrupt disabled, then enabled, then acked
    wr(5'h08, 32'd2);
    wr(5'h04, 32'h6);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1; tick = 1'b0;
    end
    rd(5'h00, v); chk("R8 timeout auto", v, 32'h3);
    chk("R10 irq masked", {31'b0, irq}, 0);
    wr(5'h04, 32'h3);
    chk("R10 irq enabled", {31'b0, irq}, 1);
    rd(5'h00, v); chk("R4 no command keeps run", v, 32'h3);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); chk("R3 ack keeps run", v, 32'h2);
    chk("R3 irq dropped", {31'b0, irq}, 0);
    wr(5'h04, 32'h8);

    // R6 live count write ignored
    wr(5'h08, 32'd9);
    wr(5'h0C, 32'h1234);
    rd(5'h0C, v); chk("R6 live unchanged", v, 9);
    rd(5'h08, v); chk("R6 reload unchanged", v, 9);

    // R11 unmapped and misaligned
    wr(5'h14, 32'hAAAA);
    wr(5'h09, 32'h55);
    rd(5'h14, v); chk("R11 unmapped read", v, 0);
    rd(5'h05, v); chk("R11 misaligned read", v, 0);
    rd(5'h08, v); chk("R11 reload untouched", v, 9);
    rd(5'h04, v); chk("R11 ctrl untouched", v, 32'h8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule